// File: doc/BRIEF.md
# VME Slave Buffer Control Sequencer

This block drives the control pins of the external buffers that sit between the VME backplane and a card's internal bus. It sets the direction and output-enables of the data transceiver and the on-card data translator, and the latch-enable and output-enable of the address/control receivers. It also sets the direction and enable of the address/control translator and produces an active-low request to assert the bus acknowledge (DTACK). Its inputs are already decoded: a card-selected strobe, the read/write direction, the active-low data strobes, a "local logic done" indication and a card-ready level.

Every output idles high, which is the safe level the pins hold before the device is configured. While the card is not ready, every output stays high. A transfer runs through five steps: set direction, drive, acknowledge, release and idle. The sequence guarantees that direction is settled before any output-enable falls, and that the output-enables rise before direction may change. An optional hold mode pulls the address-receiver latch-enable low for the duration of a transfer, so the receiver keeps the captured address.

All pins are plain levels. No data flows through this block, so it has no valid/ready handshake.

Top module: `vme_buf_seq`

## Requirements
- R1: One clock edge after `card_ready` is sampled low, every output is high, whatever the state of the transfer. This includes the state out of reset.
- R2: `vme_dat_dir` and `ocb_dat_dir` are equal on every cycle. Each is loaded at the start of a transfer with `rd_wr` (1 = read gives high, 0 = write gives low).
- R3: A transfer starts on the first edge at which the sequencer is idle while `card_ready`, `card_sel` and at least one low bit of `ds_n` are all sampled. Both data output-enables are low from the second edge after the start until release, and high at all other times.
- R4: The data direction lines take their new value one edge before the output-enables fall, and they do not change while an output-enable is low unless `card_ready` drops.
- R5: `ctl_rx_le` is high on every cycle.
- R6: With `addr_hold_en` = 0 sampled at the start, `adr_rx_le` stays high. With `addr_hold_en` = 1, `adr_rx_le` is low from the first edge after the start until the release edge.
- R7: One edge after `card_ready` is sampled high, `adrctl_rx_oe_n`, `adrctl_xl_dir` and `adrctl_xl_oe_n` are low, and they stay low while the card stays ready.
- R8: While driving, `dtack_req_n` goes low one edge after `local_done` is sampled high. It is never low while the data output-enables are high.
- R9: Once `ds_n` is sampled all ones during the acknowledge step, `dtack_req_n` and both data output-enables are high one edge later. The sequencer is idle one edge after that.
- R10: If all data strobes are removed before `local_done` is seen, the transfer is abandoned without any DTACK request, and the output-enables rise one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_ready | input | 1 | Card is ready for VME access |
| addr_hold_en | input | 1 | 1 = hold the address receiver latch during a transfer |
| card_sel | input | 1 | Decoded card-selected strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ds_n | input | DS_W | Active-low data strobes |
| local_done | input | 1 | Local logic has the transfer ready to acknowledge |
| vme_dat_dir | output | 1 | VME data transceiver direction |
| ocb_dat_dir | output | 1 | On-card data translator direction |
| vme_dat_oe_n | output | 1 | VME data transceiver output-enable, active low |
| ocb_dat_oe_n | output | 1 | On-card data translator output-enable, active low |
| adr_rx_le | output | 1 | Address receiver latch-enable (high = transparent) |
| ctl_rx_le | output | 1 | Control receiver latch-enable (held high) |
| adrctl_rx_oe_n | output | 1 | Address/control receiver output-enable, active low |
| adrctl_xl_dir | output | 1 | Address/control translator direction (low = B to A) |
| adrctl_xl_oe_n | output | 1 | Address/control translator output-enable, active low |
| dtack_req_n | output | 1 | Request to assert DTACK, active low |

## Verification
Two functions can fall in the same cycle: a change of the data direction, and an output-enable being low. Loss of card readiness can also arrive in the very cycle in which a transfer is being driven. The bench runs back-to-back reads and writes so that direction flips between transfers, and drops `card_ready` during the drive step. It judges every cycle that the two direction lines agree, and that no output-enable is low in a cycle after readiness was sampled low. A scoreboard pairs each acknowledged transfer with the direction and hold mode it was started with.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETDIR  = 3'd1,
    ST_DRIVE   = 3'd2,
    ST_ACK     = 3'd3,
    ST_RELEASE = 3'd4
  } seq_st_e;
endpackage

// File: rtl/vbs_seq_fsm.sv
module vbs_seq_fsm
  import vbs_pkg::*;
#(
  parameter int DS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            card_ready,
  input  logic            card_sel,
  input  logic [DS_W-1:0] ds_n,
  input  logic            local_done,
  output seq_st_e         st_q,
  output logic            rdy_q,
  output logic            start_o
);
  localparam logic [DS_W-1:0] DS_IDLE = '1;

  seq_st_e st_d;
  logic    strobe_any;

  assign strobe_any = (ds_n != DS_IDLE);
  assign start_o    = (st_q == ST_IDLE) && card_ready && card_sel && strobe_any;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_o) st_d = ST_SETDIR;
      ST_SETDIR:  st_d = ST_DRIVE;
      ST_DRIVE: begin
        if (!strobe_any)     st_d = ST_RELEASE;
        else if (local_done) st_d = ST_ACK;
      end
      ST_ACK:     if (!strobe_any) st_d = ST_RELEASE;
      ST_RELEASE: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (!card_ready) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= card_ready;
    end
  end

  // R9: acknowledge with strobes gone always moves on to release
  a_r9_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK && !strobe_any && card_ready) |=> (st_q == ST_RELEASE));
  // R10: strobes removed while driving abandon the transfer
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRIVE && !strobe_any && card_ready) |=> (st_q == ST_RELEASE));
endmodule

// File: rtl/vbs_dir_pair.sv
module vbs_dir_pair #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         card_ready,
  input  logic         load,
  input  logic         rd_sel,
  output logic [N-1:0] dir_q
);
  localparam int LAST = N - 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           dir_q[g] <= 1'b1;
      else if (!card_ready) dir_q[g] <= 1'b1;
      else if (load)        dir_q[g] <= rd_sel;
    end
  end

  // R2: separately held direction lines never disagree
  a_r2_dir_lock: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[0] == dir_q[LAST]);
endmodule

// File: rtl/vbs_out_drive.sv
module vbs_out_drive
  import vbs_pkg::*;
(
  input  seq_st_e st_q,
  input  logic    rdy_q,
  input  logic    hold_q,
  output logic    vme_oe_n,
  output logic    ocb_oe_n,
  output logic    adr_le,
  output logic    ctl_le,
  output logic    ac_rx_oe_n,
  output logic    ac_xl_dir,
  output logic    ac_xl_oe_n,
  output logic    dtack_n
);
  logic driving, in_xfer;

  assign driving = (st_q == ST_DRIVE) || (st_q == ST_ACK);
  assign in_xfer = driving || (st_q == ST_SETDIR);

  always_comb begin
    vme_oe_n   = !(rdy_q && driving);
    ocb_oe_n   = !(rdy_q && driving);
    dtack_n    = !(rdy_q && (st_q == ST_ACK));
    adr_le     = !(rdy_q && hold_q && in_xfer);
    ctl_le     = 1'b1;
    ac_rx_oe_n = !rdy_q;
    ac_xl_dir  = !rdy_q;
    ac_xl_oe_n = !rdy_q;
  end
endmodule

// File: rtl/vme_buf_seq.sv
module vme_buf_seq
  import vbs_pkg::*;
#(
  parameter int DS_W      = 2,
  parameter int DIR_LINES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            card_ready,
  input  logic            addr_hold_en,
  input  logic            card_sel,
  input  logic            rd_wr,
  input  logic [DS_W-1:0] ds_n,
  input  logic            local_done,
  output logic            vme_dat_dir,
  output logic            ocb_dat_dir,
  output logic            vme_dat_oe_n,
  output logic            ocb_dat_oe_n,
  output logic            adr_rx_le,
  output logic            ctl_rx_le,
  output logic            adrctl_rx_oe_n,
  output logic            adrctl_xl_dir,
  output logic            adrctl_xl_oe_n,
  output logic            dtack_req_n
);
  localparam int DIR_LAST = DIR_LINES - 1;

  seq_st_e              st_q;
  logic                 rdy_q, start, hold_q;
  logic [DIR_LINES-1:0] dir_q;

  vbs_seq_fsm #(.DS_W(DS_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .card_sel(card_sel),
    .ds_n(ds_n), .local_done(local_done), .st_q(st_q), .rdy_q(rdy_q),
    .start_o(start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_q <= 1'b0;
    else if (!card_ready) hold_q <= 1'b0;
    else if (start)       hold_q <= addr_hold_en;
  end

  vbs_dir_pair #(.N(DIR_LINES)) u_dir (
    .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .load(start),
    .rd_sel(rd_wr), .dir_q(dir_q)
  );

  assign vme_dat_dir = dir_q[0];
  assign ocb_dat_dir = dir_q[DIR_LAST];

  vbs_out_drive u_drv (
    .st_q(st_q), .rdy_q(rdy_q), .hold_q(hold_q),
    .vme_oe_n(vme_dat_oe_n), .ocb_oe_n(ocb_dat_oe_n),
    .adr_le(adr_rx_le), .ctl_le(ctl_rx_le),
    .ac_rx_oe_n(adrctl_rx_oe_n), .ac_xl_dir(adrctl_xl_dir),
    .ac_xl_oe_n(adrctl_xl_oe_n), .dtack_n(dtack_req_n)
  );

  // R1: loss of readiness parks every pin high
  a_r1_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !card_ready |=> (vme_dat_oe_n && ocb_dat_oe_n && dtack_req_n && adr_rx_le &&
                     adrctl_rx_oe_n && adrctl_xl_dir && adrctl_xl_oe_n &&
                     vme_dat_dir && ocb_dat_dir));
  // R4: direction is already settled when an enable falls
  a_r4_dir_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vme_dat_oe_n) |-> $stable(vme_dat_dir));
  // R4: direction moves only behind a raised enable while ready
  a_r4_oe_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vme_dat_dir) && $past(card_ready)) |-> $past(vme_dat_oe_n));
  // R7: ready card opens the address/control path
  a_r7_ac_open: assert property (@(posedge clk) disable iff (!rst_n)
    card_ready |=> (!adrctl_rx_oe_n && !adrctl_xl_dir && !adrctl_xl_oe_n));
  // R8: no acknowledge request without driven buffers
  a_r8_dtack_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_req_n |-> (!vme_dat_oe_n && !ocb_dat_oe_n));
  // R9: strobes gone during acknowledge release everything next edge
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_req_n && (&ds_n)) |=> (dtack_req_n && vme_dat_oe_n && ocb_dat_oe_n));
endmodule

// File: tb/tb_vme_buf_seq.sv
module tb_vme_buf_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_ready = 1'b0, addr_hold_en = 1'b0, card_sel = 1'b0;
  logic       rd_wr = 1'b0, local_done = 1'b0;
  logic [1:0] ds_n = 2'b11;
  logic vme_dat_dir, ocb_dat_dir, vme_dat_oe_n, ocb_dat_oe_n, adr_rx_le;
  logic ctl_rx_le, adrctl_rx_oe_n, adrctl_xl_dir, adrctl_xl_oe_n, dtack_req_n;

  int n_tests = 0, n_fail = 0;
  int cyc_viol_r1 = 0, cyc_viol_r2 = 0, cyc_viol_r5 = 0;
  bit finished = 1'b0;
  logic rdy_s = 1'b0;
  logic prev_dtack = 1'b1;
  logic [1:0] exp_q[$];   // {read, hold mode} per acknowledged transfer

  always #4 clk = ~clk;

  vme_buf_seq dut (
    .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .addr_hold_en(addr_hold_en),
    .card_sel(card_sel), .rd_wr(rd_wr), .ds_n(ds_n), .local_done(local_done),
    .vme_dat_dir(vme_dat_dir), .ocb_dat_dir(ocb_dat_dir),
    .vme_dat_oe_n(vme_dat_oe_n), .ocb_dat_oe_n(ocb_dat_oe_n),
    .adr_rx_le(adr_rx_le), .ctl_rx_le(ctl_rx_le),
    .adrctl_rx_oe_n(adrctl_rx_oe_n), .adrctl_xl_dir(adrctl_xl_dir),
    .adrctl_xl_oe_n(adrctl_xl_oe_n), .dtack_req_n(dtack_req_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit all_high();
    return vme_dat_oe_n && ocb_dat_oe_n && dtack_req_n && adr_rx_le && ctl_rx_le &&
           adrctl_rx_oe_n && adrctl_xl_dir && adrctl_xl_oe_n && vme_dat_dir && ocb_dat_dir;
  endfunction

  // readiness as the design saw it at the last edge
  always @(posedge clk) rdy_s <= card_ready;

  // per-cycle monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (vme_dat_dir !== ocb_dat_dir) cyc_viol_r2++;
      if (!rdy_s && (!vme_dat_oe_n || !ocb_dat_oe_n)) cyc_viol_r1++;
      if (ctl_rx_le !== 1'b1) cyc_viol_r5++;
      if (prev_dtack && !dtack_req_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected dtack request", 0, 1);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(vme_dat_dir == e[1] && ocb_dat_dir == e[1], "R2", "dir at ack",
              int'(vme_dat_dir), int'(e[1]));
          chk(!vme_dat_oe_n && !ocb_dat_oe_n, "R8", "oe low at ack",
              int'(vme_dat_oe_n), 0);
          chk(adr_rx_le == !e[0], "R6", "addr le at ack", int'(adr_rx_le), int'(!e[0]));
        end
      end
    end
    prev_dtack = dtack_req_n;
  end

  task automatic vme_cycle(input bit rd, input bit mode, input int nwait, input bit abort);
    @(negedge clk);
    addr_hold_en = mode; rd_wr = rd; card_sel = 1'b1; ds_n = 2'b00;
    if (!abort) exp_q.push_back({rd, mode});
    @(negedge clk);  // set-direction step
    chk(vme_dat_dir == rd && ocb_dat_dir == rd, "R2", "dir set", int'(vme_dat_dir), int'(rd));
    chk(vme_dat_oe_n && ocb_dat_oe_n, "R4", "oe still high while dir settles",
        int'(vme_dat_oe_n), 1);
    chk(adr_rx_le == !mode, "R6", "addr le at start", int'(adr_rx_le), int'(!mode));
    @(negedge clk);  // drive step
    chk(!vme_dat_oe_n && !ocb_dat_oe_n, "R3", "oe low when driving", int'(vme_dat_oe_n), 0);
    chk(vme_dat_dir == rd, "R4", "dir stable over oe fall", int'(vme_dat_dir), int'(rd));
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk);
      chk(dtack_req_n, "R8", "no early dtack", int'(dtack_req_n), 1);
    end
    if (abort) begin
      ds_n = 2'b11; card_sel = 1'b0;
      @(negedge clk);
      chk(vme_dat_oe_n && ocb_dat_oe_n && dtack_req_n, "R10", "abandon releases",
          int'(vme_dat_oe_n), 1);
      @(negedge clk);
      chk(adr_rx_le, "R6", "addr le back high", int'(adr_rx_le), 1);
      return;
    end
    local_done = 1'b1;
    @(negedge clk);  // acknowledge step
    chk(!dtack_req_n, "R8", "dtack after done", int'(dtack_req_n), 0);
    ds_n = 2'b10;    // one strobe still active: acknowledge holds
    @(negedge clk);
    chk(!dtack_req_n, "R9", "dtack held with one strobe", int'(dtack_req_n), 0);
    ds_n = 2'b11; card_sel = 1'b0; local_done = 1'b0;
    @(negedge clk);  // release step
    chk(dtack_req_n && vme_dat_oe_n && ocb_dat_oe_n, "R9", "release",
        int'(dtack_req_n), 1);
    chk(vme_dat_dir == rd, "R4", "dir held behind raised oe", int'(vme_dat_dir), int'(rd));
    chk(adr_rx_le, "R6", "addr le released", int'(adr_rx_le), 1);
    @(negedge clk);  // idle again
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(all_high(), "R1", "reset state all high", 0, 1);
    rst_n = 1'b1;
    // not ready: a selected cycle must not open anything
    card_sel = 1'b1; ds_n = 2'b00; rd_wr = 1'b1;
    repeat (4) @(negedge clk);
    chk(all_high(), "R1", "not ready ignores strobes", int'(vme_dat_oe_n), 1);
    card_sel = 1'b0; ds_n = 2'b11;
    @(negedge clk);
    card_ready = 1'b1;
    @(negedge clk);
    chk(!adrctl_rx_oe_n && !adrctl_xl_dir && !adrctl_xl_oe_n, "R7", "ac path open",
        int'(adrctl_rx_oe_n), 0);
    chk(ctl_rx_le && adr_rx_le, "R5", "latches transparent when idle", int'(ctl_rx_le), 1);
    // transfers with direction flips and both latch modes
    vme_cycle(1'b1, 1'b0, 0, 1'b0);
    vme_cycle(1'b0, 1'b0, 2, 1'b0);
    vme_cycle(1'b1, 1'b1, 1, 1'b0);
    vme_cycle(1'b0, 1'b1, 3, 1'b0);
    vme_cycle(1'b1, 1'b0, 1, 1'b1);
    vme_cycle(1'b0, 1'b1, 0, 1'b0);
    // readiness dropped while driving
    @(negedge clk);
    card_sel = 1'b1; ds_n = 2'b00; rd_wr = 1'b0; addr_hold_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(!vme_dat_oe_n, "R3", "driving before ready loss", int'(vme_dat_oe_n), 0);
    card_ready = 1'b0;
    @(negedge clk);
    chk(all_high(), "R1", "ready loss parks pins", int'(vme_dat_oe_n), 1);
    card_sel = 1'b0; ds_n = 2'b11;
    @(negedge clk);
    card_ready = 1'b1;
    repeat (2) @(negedge clk);
    vme_cycle(1'b1, 1'b1, 0, 1'b0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "every transfer acknowledged", exp_q.size(), 0);
    chk(cyc_viol_r2 == 0, "R2", "direction lines agree every cycle", cyc_viol_r2, 0);
    chk(cyc_viol_r1 == 0, "R1", "no oe low while not ready", cyc_viol_r1, 0);
    chk(cyc_viol_r5 == 0, "R5", "control le high every cycle", cyc_viol_r5, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule